// File: doc/BRIEF.md
# Power Domain Sequencing Controller

This block switches a set of on-chip power domains on and off when software asks. Software drives it over a simple 32-bit register bus. Each domain has a small address window. In that window, software writes a power-up or power-down command, reads the domain's state, and reads an error flag. The error flag shows whether the last command was refused. A physical power switch per domain is modelled by two signals. The controller drives an enable output to the switch, and the switch answers through an acknowledge input. A domain finishes its transition once the acknowledge matches the enable.

Each domain has a completion flag. The flags are packed 32 to a word, next to per-word enable and mask words. A completed transition is recorded only for enabled domains. Software clears a flag by writing 1 to its bit. The interrupt line is raised by any flag that is recorded, enabled and not masked. A global status word reports whether the controller can take a new command. Software is expected to poll that word, issue the command, retry while the error flag is set, then wait for the completion flag.

Top module: `pds_ctrl`

## Requirements
- R1: After reset every domain is off and its power enable is low. The global ready field reads 0b11. All completion flags, enable words and mask words read 0, and the interrupt output is low.
- R2: A domain's status word at window offset +0x0 has exactly one of four bits set. Bit 0 means off, bit 4 means on, bit 8 means powering down and bit 12 means powering up.
- R3: Domain n's window starts at 0x1000 + n*0x40. A write with bit 0 set to +0x4 moves an off domain into powering up and raises its power enable. The domain becomes on in the cycle after its acknowledge input reads 1. A write with bit 0 set to +0x8 moves an on domain into powering down and drops its enable. The domain becomes off in the cycle after its acknowledge reads 0.
- R4: The global status word at 0x000 holds a 2-bit ready field in bits 1:0. It reads 0b11 when no domain is in a transition and 0b00 while any domain is powering up or down.
- R5: A command to a domain that is mid-transition is refused. The refusal sets bit 0 of the domain's error word at +0xC and leaves its state unchanged. A command that is accepted clears that bit.
- R6: A command for the state a domain already holds completes at once. It leaves the state unchanged and records a completion for that domain.
- R7: Domain n's completion flag, enable bit and mask bit sit in bit n%32 of word n/32. Those words start at 0x810, 0x820 and 0x830, with a 4-byte stride. A completion sets the flag only when the enable bit is 1.
- R8: Writing the completion word clears each flag whose data bit is 1. Flags whose data bit is 0 are left unchanged.
- R9: The interrupt output is high exactly when some flag is set, enabled and not masked. Setting the mask bit silences the interrupt but does not stop the flag from being recorded.
- R10: Reads of unmapped addresses return 0, including windows of domains that do not exist. Command writes with bit 0 clear have no effect.
- R11: Every read or write strobe is answered by ready_o one cycle later. Read data is valid in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 16 | Byte address |
| wr_i | input | 1 | Write strobe, one cycle |
| rd_i | input | 1 | Read strobe, one cycle |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid with ready_o |
| ready_o | output | 1 | Access acknowledge |
| pwr_en_o | output | NUM_DOM | Per-domain power switch enable |
| pwr_ack_i | input | NUM_DOM | Per-domain power switch acknowledge |
| irq_o | output | 1 | Completion interrupt |

## Verification
The bench builds the block with NUM_DOM set to 36. This places domains in two completion words, and a domain above 31 exercises the word-index and bit-index split and the second register of each array. Domain indices 36 and above still decode into the per-domain window region, so reads there check that windows of nonexistent domains return zero. The power switches are modelled in the bench by driving each acknowledge input by hand. This lets a domain be held mid-transition for as long as needed, so the refusal path and the zero ready field can be observed.

// File: rtl/pds_pkg.sv
package pds_pkg;
  typedef enum logic [1:0] {
    D_OFF  = 2'd0,
    D_ON   = 2'd1,
    D_DOWN = 2'd2,
    D_UP   = 2'd3
  } dom_state_e;

  localparam logic [15:0] GSTAT_ADDR  = 16'h0000;
  localparam logic [11:0] FLAG_PAGE   = 12'h081;
  localparam logic [11:0] EN_PAGE     = 12'h082;
  localparam logic [11:0] MASK_PAGE   = 12'h083;
  localparam logic [15:0] DOM_BASE    = 16'h1000;
  localparam int          DOM_SHIFT   = 6;
  localparam logic [5:0]  OFS_STAT    = 6'h00;
  localparam logic [5:0]  OFS_ON      = 6'h04;
  localparam logic [5:0]  OFS_OFF     = 6'h08;
  localparam logic [5:0]  OFS_ERR     = 6'h0C;

  // status word: off b0, on b4, powering down b8, powering up b12
  function automatic logic [31:0] stat_word(input logic [3:0] s);
    return {19'd0, s[3], 3'd0, s[2], 3'd0, s[1], 3'd0, s[0]};
  endfunction
endpackage

// File: rtl/pds_domain.sv
module pds_domain
  import pds_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       on_cmd_i,
  input  logic       off_cmd_i,
  input  logic       ack_i,
  output logic       pwr_en_o,
  output logic [3:0] st_o,     // {up, down, on, off}
  output logic       busy_o,
  output logic       err_o,
  output logic       done_o
);
  dom_state_e st_q;
  logic       err_q;
  logic       cmd;

  assign cmd    = on_cmd_i | off_cmd_i;
  assign busy_o = (st_q == D_UP) || (st_q == D_DOWN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= D_OFF;
      err_q <= 1'b0;
    end else if (cmd) begin
      err_q <= busy_o;
      if (on_cmd_i && st_q == D_OFF) st_q <= D_UP;
      if (off_cmd_i && st_q == D_ON) st_q <= D_DOWN;
    end else if (st_q == D_UP && ack_i) begin
      st_q <= D_ON;
    end else if (st_q == D_DOWN && !ack_i) begin
      st_q <= D_OFF;
    end
  end

  always_comb begin
    done_o = 1'b0;
    if (on_cmd_i && st_q == D_ON)          done_o = 1'b1;
    if (off_cmd_i && st_q == D_OFF)        done_o = 1'b1;
    if (!cmd && st_q == D_UP && ack_i)     done_o = 1'b1;
    if (!cmd && st_q == D_DOWN && !ack_i)  done_o = 1'b1;
  end

  assign pwr_en_o = (st_q == D_ON) || (st_q == D_UP);
  assign err_o    = err_q;
  assign st_o     = {st_q == D_UP, st_q == D_DOWN, st_q == D_ON, st_q == D_OFF};
endmodule

// File: rtl/pds_irq.sv
module pds_irq #(
  parameter int NW = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NW*32-1:0] done_i,
  input  logic [31:0]      wdata_i,
  input  logic [NW-1:0]    flag_we_i,
  input  logic [NW-1:0]    en_we_i,
  input  logic [NW-1:0]    mask_we_i,
  output logic [NW*32-1:0] flag_o,
  output logic [NW*32-1:0] en_o,
  output logic [NW*32-1:0] mask_o,
  output logic             irq_o
);
  logic [NW-1:0] word_irq;

  for (genvar w = 0; w < NW; w++) begin : g_word
    logic [31:0] flag_q, en_q, mask_q, clr;
    assign clr = flag_we_i[w] ? wdata_i : 32'd0;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        flag_q <= '0;
        en_q   <= '0;
        mask_q <= '0;
      end else begin
        // a new completion wins over a same-cycle clear
        flag_q <= (flag_q & ~clr) | (done_i[w*32 +: 32] & en_q);
        if (en_we_i[w])   en_q   <= wdata_i;
        if (mask_we_i[w]) mask_q <= wdata_i;
      end
    end

    assign flag_o[w*32 +: 32] = flag_q;
    assign en_o[w*32 +: 32]   = en_q;
    assign mask_o[w*32 +: 32] = mask_q;
    assign word_irq[w]        = |(flag_q & en_q & ~mask_q);
  end

  assign irq_o = |word_irq;
endmodule

// File: rtl/pds_ctrl.sv
module pds_ctrl
  import pds_pkg::*;
#(
  parameter int NUM_DOM = 36
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [15:0]        addr_i,
  input  logic               wr_i,
  input  logic               rd_i,
  input  logic [31:0]        wdata_i,
  output logic [31:0]        rdata_o,
  output logic               ready_o,
  output logic [NUM_DOM-1:0] pwr_en_o,
  input  logic [NUM_DOM-1:0] pwr_ack_i,
  output logic               irq_o
);
  // word arrays have room for 4 words before the next array starts
  localparam int NW  = (NUM_DOM + 31) / 32;
  localparam int FW  = NW * 32;
  localparam int DIW = 16 - DOM_SHIFT;

  logic [DIW-1:0]     dom_idx;
  logic               dom_hit;
  logic [5:0]         dom_ofs;
  logic [1:0]         w_idx;
  logic               w_ok;
  logic               flag_hit, en_hit, mask_hit;
  logic [NUM_DOM-1:0] on_cmd, off_cmd, busy, err;
  logic [FW-1:0]      done;
  logic [4*NUM_DOM-1:0] dom_st;
  logic [NW-1:0]      flag_we, en_we, mask_we;
  logic [FW-1:0]      flag, en, mask;
  logic [1:0]         rdy;
  logic [31:0]        rd_mux;
  logic [15:0]        dom_addr;

  assign dom_addr = addr_i - DOM_BASE;
  assign dom_idx  = dom_addr[15:DOM_SHIFT];
  assign dom_ofs  = addr_i[5:0];
  assign dom_hit  = (addr_i >= DOM_BASE) && (int'(dom_idx) < NUM_DOM);
  assign w_idx    = addr_i[3:2];
  assign w_ok     = (int'(w_idx) < NW) && (addr_i[1:0] == 2'b00);
  assign flag_hit = (addr_i[15:4] == FLAG_PAGE) && w_ok;
  assign en_hit   = (addr_i[15:4] == EN_PAGE) && w_ok;
  assign mask_hit = (addr_i[15:4] == MASK_PAGE) && w_ok;

  for (genvar n = 0; n < NUM_DOM; n++) begin : g_dom
    logic sel;
    assign sel        = wr_i && wdata_i[0] && dom_hit && (int'(dom_idx) == n);
    assign on_cmd[n]  = sel && (dom_ofs == OFS_ON);
    assign off_cmd[n] = sel && (dom_ofs == OFS_OFF);

    pds_domain u_dom (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .on_cmd_i  (on_cmd[n]),
      .off_cmd_i (off_cmd[n]),
      .ack_i     (pwr_ack_i[n]),
      .pwr_en_o  (pwr_en_o[n]),
      .st_o      (dom_st[4*n +: 4]),
      .busy_o    (busy[n]),
      .err_o     (err[n]),
      .done_o    (done[n])
    );
  end

  if (FW > NUM_DOM) begin : g_pad
    assign done[FW-1:NUM_DOM] = '0;
  end

  for (genvar w = 0; w < NW; w++) begin : g_we
    assign flag_we[w] = wr_i && flag_hit && (int'(w_idx) == w);
    assign en_we[w]   = wr_i && en_hit && (int'(w_idx) == w);
    assign mask_we[w] = wr_i && mask_hit && (int'(w_idx) == w);
  end

  pds_irq #(.NW(NW)) u_irq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .done_i    (done),
    .wdata_i   (wdata_i),
    .flag_we_i (flag_we),
    .en_we_i   (en_we),
    .mask_we_i (mask_we),
    .flag_o    (flag),
    .en_o      (en),
    .mask_o    (mask),
    .irq_o     (irq_o)
  );

  assign rdy = (|busy) ? 2'b00 : 2'b11;

  always_comb begin
    rd_mux = '0;
    if (addr_i == GSTAT_ADDR)  rd_mux = {30'd0, rdy};
    else if (flag_hit)         rd_mux = flag[int'(w_idx)*32 +: 32];
    else if (en_hit)           rd_mux = en[int'(w_idx)*32 +: 32];
    else if (mask_hit)         rd_mux = mask[int'(w_idx)*32 +: 32];
    else if (dom_hit) begin
      if (dom_ofs == OFS_STAT)     rd_mux = stat_word(dom_st[int'(dom_idx)*4 +: 4]);
      else if (dom_ofs == OFS_ERR) rd_mux = {31'd0, err[dom_idx]};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o <= '0;
      ready_o <= 1'b0;
    end else begin
      ready_o <= rd_i | wr_i;
      rdata_o <= rd_i ? rd_mux : 32'd0;
    end
  end
endmodule

// File: rtl/pds_ctrl_chk.sv
module pds_ctrl_chk #(
  parameter int NUM_DOM = 36
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 wr_i,
  input logic                 rd_i,
  input logic                 ready_o,
  input logic [NUM_DOM-1:0]   pwr_en_o,
  input logic [NUM_DOM-1:0]   pwr_ack_i,
  input logic [4*NUM_DOM-1:0] dom_st
);
  // R11
  bus_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i || rd_i) |=> ready_o);

  for (genvar n = 0; n < NUM_DOM; n++) begin : g_d
    logic [3:0] s;
    assign s = dom_st[4*n +: 4];

    // R2
    st_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot(s));

    // R3
    up_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (s[3] && pwr_ack_i[n] && !wr_i) |=> s[1]);

    // R3
    down_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (s[2] && !pwr_ack_i[n] && !wr_i) |=> s[0]);

    // R3
    en_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (s[1] || s[3]) == pwr_en_o[n]);
  end
endmodule

bind pds_ctrl pds_ctrl_chk #(.NUM_DOM(NUM_DOM)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_i      (wr_i),
  .rd_i      (rd_i),
  .ready_o   (ready_o),
  .pwr_en_o  (pwr_en_o),
  .pwr_ack_i (pwr_ack_i),
  .dom_st    (dom_st)
);

// File: tb/pds_ctrl_tb.sv
module pds_ctrl_tb;
  localparam int ND = 36;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [15:0]   addr_i = '0;
  logic          wr_i = 1'b0;
  logic          rd_i = 1'b0;
  logic [31:0]   wdata_i = '0;
  logic [31:0]   rdata_o;
  logic          ready_o;
  logic [ND-1:0] pwr_en_o;
  logic [ND-1:0] pwr_ack_i = '0;
  logic          irq_o;

  int total = 0;
  int bad = 0;
  logic last_rd = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #5 clk_i = ~clk_i;

  pds_ctrl #(.NUM_DOM(ND)) u_dut (
    .clk_i, .rst_ni, .addr_i, .wr_i, .rd_i, .wdata_i,
    .rdata_o, .ready_o, .pwr_en_o, .pwr_ack_i, .irq_o
  );

  function automatic logic [15:0] dom_a(input int n, input int ofs);
    return 16'(32'h1000 + n * 32'h40 + ofs);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // monitor: compare read data as it is returned
  always @(posedge clk_i) last_rd <= rd_i;
  always @(negedge clk_i) begin
    if (rst_ni && last_rd) begin
      check("R11 ready", {31'd0, ready_o}, 32'd1);
      if (exp_q.size() > 0) check(tag_q.pop_front(), rdata_o, exp_q.pop_front());
    end
  end

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; wr_i = 1'b1;
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk_i);
    addr_i = a; rd_i = 1'b1;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk_i);
    rd_i = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1 reset state
    check("R1 irq", {31'd0, irq_o}, 0);
    check("R1 pwr_en", 32'(pwr_en_o), 0);
    rd(16'h0000, 32'h3, "R1 ready field");
    rd(dom_a(3, 0), 32'h1, "R1 R2 status off");
    rd(16'h0810, 0, "R1 flags");
    rd(16'h0824, 0, "R1 enable");

    wr(16'h0820, 32'h8);
    wr(16'h0824, 32'h2);
    // R3 power up domain 3
    wr(dom_a(3, 4), 1);
    check("R3 pwr_en up", {31'd0, pwr_en_o[3]}, 1);
    rd(dom_a(3, 0), 32'h1000, "R2 R3 powering up");
    rd(16'h0000, 32'h0, "R4 busy ready");
    // R5 refused while busy
    wr(dom_a(3, 4), 1);
    rd(dom_a(3, 12), 1, "R5 error set");
    rd(dom_a(3, 0), 32'h1000, "R5 state kept");
    pwr_ack_i[3] = 1'b1;
    idle(1);
    rd(dom_a(3, 0), 32'h10, "R3 on");
    rd(16'h0810, 32'h8, "R7 flag set");
    check("R9 irq high", {31'd0, irq_o}, 1);
    rd(16'h0000, 32'h3, "R4 idle ready");
    // R9 mask
    wr(16'h0830, 32'h8);
    check("R9 masked irq", {31'd0, irq_o}, 0);
    // R8 write-1-clear
    wr(16'h0810, 32'h0);
    rd(16'h0810, 32'h8, "R8 zero keeps");
    wr(16'h0810, 32'h8);
    rd(16'h0810, 32'h0, "R8 one clears");
    // R6 same-state command, R5 accepted clears error
    wr(dom_a(3, 4), 1);
    rd(dom_a(3, 12), 0, "R5 error cleared");
    rd(16'h0810, 32'h8, "R6 R9 immediate flag under mask");
    rd(dom_a(3, 0), 32'h10, "R6 state kept");
    check("R9 still masked", {31'd0, irq_o}, 0);
    wr(16'h0810, 32'h8);

    // domain 33: second word, bit 1
    wr(dom_a(33, 4), 1);
    pwr_ack_i[33] = 1'b1;
    idle(1);
    rd(16'h0814, 32'h2, "R7 word1 bit1");
    check("R9 word1 irq", {31'd0, irq_o}, 1);
    wr(16'h0814, 32'h2);
    wr(dom_a(33, 8), 1);
    check("R3 pwr_en down", {31'd0, pwr_en_o[33]}, 0);
    rd(dom_a(33, 0), 32'h100, "R2 R3 powering down");
    pwr_ack_i[33] = 1'b0;
    idle(1);
    rd(dom_a(33, 0), 32'h1, "R3 off");
    rd(16'h0814, 32'h2, "R7 off completion");

    // R7 not enabled domain 5
    wr(dom_a(5, 4), 1);
    pwr_ack_i[5] = 1'b1;
    idle(1);
    rd(dom_a(5, 0), 32'h10, "R3 d5 on");
    rd(16'h0810, 32'h0, "R7 disabled not recorded");

    // R10 unmapped and ignored writes
    rd(16'h0100, 0, "R10 unmapped");
    rd(dom_a(40, 0), 0, "R10 no such domain");
    wr(dom_a(3, 8), 0);
    rd(dom_a(3, 0), 32'h10, "R10 bit0 clear ignored");
    check("R10 pwr_en kept", {31'd0, pwr_en_o[3]}, 1);

    idle(3);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    total++; bad++;
    $display("FAIL watchdog act=hang exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule